// File: doc/BRIEF.md
# Virtual Link Transmit Bandwidth Regulator

This block schedules frame transmissions for an end system that carries several virtual links over one shared physical output. Every link has two fixed settings. The first is a minimum spacing between the starts of successive frames, chosen as a power-of-two number of milliseconds from 1 to 128. The second is a cap on frame length in bytes. Upstream logic announces that a frame is ready on a link and gives its length. The regulator holds that request until the link's spacing timer has expired. It then grants the output to one link at a time.

A millisecond strobe drives one down-counter per link. When a link is granted, its counter is loaded with the spacing value. The link becomes eligible again once the counter has drained to zero. When several links are pending and eligible together, a rotating-priority arbiter picks the first one after the link granted most recently. Only one grant can be outstanding. The transmitter ends a grant by pulsing a done signal. A request that exceeds its link's length cap is dropped and flagged with a single-cycle error pulse, and the link's timer is left unchanged.

Top module: `vl_tx_regulator`

## Requirements
- R1: After reset, no grant is outstanding, the error output is low, and every link is eligible. A first request on any link is granted without waiting for any millisecond strobe.
- R2: A request is sampled on a rising edge when `req_valid` is high. If the link is eligible and no grant is outstanding, `grant_valid` rises on the second rising edge after that sample, carrying the link number and the stored length.
- R3: While `grant_valid` is high, `grant_link` and `grant_len` stay stable until `tx_done` is sampled high. `grant_valid` is low after the edge that samples `tx_done`.
- R4: At most one grant is outstanding at a time. After a grant is released, a new grant can appear no earlier than one edge after the edge on which `grant_valid` fell, even when other links are already pending.
- R5: The spacing exponent e of a link is a 3-bit field at bits [3*i+2:3*i] of `cfg_bag_exp`, and it means 2^e strobes (1 to 128). The link is granted again only after 2^e strobes have been sampled after the edge that issued its previous grant. A strobe sampled on that issuing edge is not counted. The link becomes eligible on the edge after the last of those strobes.
- R6: The length cap of link i is at bits [LEN_W*i+LEN_W-1:LEN_W*i] of `cfg_max_len`. A request whose length is greater than the cap makes `req_err` high for exactly the one cycle after the sampling edge. That request is discarded and does not touch the link's timer. A length equal to the cap is accepted.
- R7: Among links that are both pending and eligible, the grant goes to the first one found in ascending order that wraps around, starting just after the most recently granted link. Right after reset, link 0 has the highest priority.
- R8: Each link's counter decrements on every strobe while it is non-zero, whether or not a grant is outstanding, and it stays at zero once it reaches zero.
- R9: A new valid request on a link that already has a pending request replaces the stored length. The link still holds only one pending frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| cfg_bag_exp | input | 3*N_LINKS | Per-link spacing exponent, 3 bits per link |
| cfg_max_len | input | LEN_W*N_LINKS | Per-link length cap in bytes |
| req_valid | input | 1 | Frame-ready request strobe |
| req_link | input | LINK_W | Link number of the request |
| req_len | input | LEN_W | Frame length of the request in bytes |
| req_err | output | 1 | One-cycle pulse: request over the length cap |
| grant_valid | output | 1 | A grant is outstanding |
| grant_link | output | LINK_W | Link that holds the grant |
| grant_len | output | LEN_W | Length of the granted frame |
| tx_done | input | 1 | Transmitter has finished the granted frame |

## Verification
The hardest situation to reach from the ports is rotating priority over several links that are all pending and eligible at once. Requests arrive one per cycle, and a lone request is granted almost at once. To get there, the stimulus first takes a grant on a middle link and holds it by withholding `tx_done`. It then queues requests on the remaining links and releases the grant, so the wrap-around order can be read off frame by frame. A second corner is a strobe that lands on the very edge that issues a grant. The bench places that strobe deliberately and then counts the strobes needed before the link comes back.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

    localparam int BAG_EXP_W = 3;
    localparam int CNT_W     = 8;

    // Convert a spacing exponent into a count of millisecond strobes.
    function automatic logic [CNT_W-1:0] bag_ticks(input logic [BAG_EXP_W-1:0] e);
        return CNT_W'(1) << e;
    endfunction

endpackage

// File: rtl/vlr_gap_timer.sv
module vlr_gap_timer
    import vlr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [BAG_EXP_W-1:0] bag_exp,
    output logic                 eligible
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            // A strobe on the issuing edge is not counted.
            st_d.cnt = bag_ticks(bag_exp);
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eligible = (st_q.cnt == '0);

endmodule

// File: rtl/vlr_len_police.sv
module vlr_len_police #(
    parameter int N_LINKS = 4,
    parameter int LEN_W   = 11,
    localparam int LINK_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
    input  logic [LINK_W-1:0]        req_link,
    input  logic [LEN_W-1:0]         req_len,
    input  logic [N_LINKS*LEN_W-1:0] cfg_max_len,
    output logic                     len_ok
);

    logic [LEN_W-1:0] limit;
    logic             in_range;

    always_comb begin
        limit    = '0;
        in_range = 1'b0;
        for (int i = 0; i < N_LINKS; i++) begin
            if (LINK_W'(i) == req_link) begin
                limit    = cfg_max_len[i*LEN_W +: LEN_W];
                in_range = 1'b1;
            end
        end
        len_ok = in_range && (req_len <= limit);
    end

endmodule

// File: rtl/vlr_rr_arbiter.sv
module vlr_rr_arbiter #(
    parameter int N_LINKS = 4,
    localparam int LINK_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINKS-1:0] req,
    input  logic               advance,
    output logic               pick_valid,
    output logic [LINK_W-1:0]  pick_idx
);

    typedef struct packed {
        logic [LINK_W-1:0] last;
    } arb_t;

    arb_t st_d, st_q;

    // Scan starts just after the most recent winner and wraps around.
    always_comb begin
        int               idx;
        logic [LINK_W-1:0] idx_w;
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int off = 1; off <= N_LINKS; off++) begin
            idx = int'(st_q.last) + off;
            if (idx >= N_LINKS) begin
                idx = idx - N_LINKS;
            end
            idx_w = LINK_W'(idx);
            if (!pick_valid && req[idx_w]) begin
                pick_valid = 1'b1;
                pick_idx   = idx_w;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (advance && pick_valid) begin
            st_d.last = pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last <= LINK_W'(N_LINKS - 1);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/vl_tx_regulator.sv
module vl_tx_regulator
    import vlr_pkg::*;
#(
    parameter int N_LINKS = 4,
    parameter int LEN_W   = 11,
    localparam int LINK_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ms_tick,
    input  logic [N_LINKS*BAG_EXP_W-1:0] cfg_bag_exp,
    input  logic [N_LINKS*LEN_W-1:0]     cfg_max_len,
    input  logic                         req_valid,
    input  logic [LINK_W-1:0]            req_link,
    input  logic [LEN_W-1:0]             req_len,
    output logic                         req_err,
    output logic                         grant_valid,
    output logic [LINK_W-1:0]            grant_link,
    output logic [LEN_W-1:0]             grant_len,
    input  logic                         tx_done
);

    typedef struct packed {
        logic [N_LINKS-1:0]            pend;
        logic [N_LINKS-1:0][LEN_W-1:0] len;
        logic                          gv;
        logic [LINK_W-1:0]             gl;
        logic [LEN_W-1:0]              glen;
        logic                          err;
    } reg_t;

    reg_t st_d, st_q;

    logic [N_LINKS-1:0] elig;
    logic [N_LINKS-1:0] load;
    logic [N_LINKS-1:0] arb_req;
    logic               arb_valid;
    logic [LINK_W-1:0]  arb_pick;
    logic               issue;
    logic               len_ok;

    // One spacing timer per link.
    for (genvar gi = 0; gi < N_LINKS; gi++) begin : g_timer
        vlr_gap_timer u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (ms_tick),
            .load     (load[gi]),
            .bag_exp  (cfg_bag_exp[gi*BAG_EXP_W +: BAG_EXP_W]),
            .eligible (elig[gi])
        );
        assign load[gi] = issue && (arb_pick == LINK_W'(gi));
    end

    vlr_len_police #(.N_LINKS(N_LINKS), .LEN_W(LEN_W)) u_police (
        .req_link    (req_link),
        .req_len     (req_len),
        .cfg_max_len (cfg_max_len),
        .len_ok      (len_ok)
    );

    assign arb_req = st_q.pend & elig;
    assign issue   = !st_q.gv && arb_valid;

    vlr_rr_arbiter #(.N_LINKS(N_LINKS)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (arb_req),
        .advance    (issue),
        .pick_valid (arb_valid),
        .pick_idx   (arb_pick)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;

        // Release of the outstanding grant.
        if (st_q.gv && tx_done) begin
            st_d.gv = 1'b0;
        end

        // New grant only when nothing is outstanding.
        if (issue) begin
            st_d.gv             = 1'b1;
            st_d.gl             = arb_pick;
            st_d.glen           = st_q.len[arb_pick];
            st_d.pend[arb_pick] = 1'b0;
        end

        // Intake; a fresh request on the link just granted re-arms it.
        if (req_valid) begin
            if (len_ok) begin
                st_d.pend[req_link] = 1'b1;
                st_d.len[req_link]  = req_len;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_err     = st_q.err;
    assign grant_valid = st_q.gv;
    assign grant_link  = st_q.gl;
    assign grant_len   = st_q.glen;

endmodule

// File: rtl/vl_tx_regulator_chk.sv
module vl_tx_regulator_chk
    import vlr_pkg::*;
#(
    parameter int N_LINKS = 4,
    parameter int LEN_W   = 11,
    localparam int LINK_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ms_tick,
    input logic [N_LINKS*BAG_EXP_W-1:0] cfg_bag_exp,
    input logic [N_LINKS*LEN_W-1:0]     cfg_max_len,
    input logic                         req_valid,
    input logic                         req_err,
    input logic                         grant_valid,
    input logic [LINK_W-1:0]            grant_link,
    input logic [LEN_W-1:0]             grant_len,
    input logic                         tx_done
);

    logic                gv_prev;
    logic [CNT_W-1:0]    gap_q [N_LINKS];
    logic [N_LINKS-1:0]  seen_q;
    logic                rise;
    logic [CNT_W-1:0]    cur_gap;
    logic                cur_seen;
    logic [CNT_W-1:0]    cur_bag;
    logic [LEN_W-1:0]    cur_max;

    assign rise = grant_valid && !gv_prev;

    always_comb begin
        cur_gap  = '0;
        cur_seen = 1'b0;
        cur_bag  = '0;
        cur_max  = '0;
        for (int i = 0; i < N_LINKS; i++) begin
            if (LINK_W'(i) == grant_link) begin
                cur_gap  = gap_q[i];
                cur_seen = seen_q[i];
                cur_bag  = bag_ticks(cfg_bag_exp[i*BAG_EXP_W +: BAG_EXP_W]);
                cur_max  = cfg_max_len[i*LEN_W +: LEN_W];
            end
        end
    end

    // Strobes seen since each link's last grant, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gv_prev <= 1'b0;
            seen_q  <= '0;
            for (int i = 0; i < N_LINKS; i++) begin
                gap_q[i] <= '0;
            end
        end else begin
            gv_prev <= grant_valid;
            for (int i = 0; i < N_LINKS; i++) begin
                if (rise && (grant_link == LINK_W'(i))) begin
                    gap_q[i]  <= ms_tick ? CNT_W'(1) : '0;
                    seen_q[i] <= 1'b1;
                end else if (ms_tick && (gap_q[i] != '1)) begin
                    gap_q[i] <= gap_q[i] + CNT_W'(1);
                end
            end
        end
    end

    assert_grant_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !tx_done) |=> (grant_valid && $stable(grant_link) && $stable(grant_len)));

    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && tx_done) |=> !grant_valid);

    assert_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && cur_seen) |-> (cur_gap >= cur_bag));

    assert_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_len <= cur_max));

    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(req_valid));

endmodule

bind vl_tx_regulator vl_tx_regulator_chk #(.N_LINKS(N_LINKS), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .cfg_bag_exp (cfg_bag_exp),
    .cfg_max_len (cfg_max_len),
    .req_valid   (req_valid),
    .req_err     (req_err),
    .grant_valid (grant_valid),
    .grant_link  (grant_link),
    .grant_len   (grant_len),
    .tx_done     (tx_done)
);

// File: tb/vl_tx_regulator_tb_top.sv
module vl_tx_regulator_tb_top;

    localparam int N  = 4;
    localparam int LW = 11;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           ms_tick;
    logic [N*3-1:0] cfg_bag_exp;
    logic [N*LW-1:0] cfg_max_len;
    logic           req_valid;
    logic [1:0]     req_link;
    logic [LW-1:0]  req_len;
    logic           req_err;
    logic           grant_valid;
    logic [1:0]     grant_link;
    logic [LW-1:0]  grant_len;
    logic           tx_done;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    vl_tx_regulator #(.N_LINKS(N), .LEN_W(LW)) dut_i (
        .clk (clk), .rst_n (rst_n), .ms_tick (ms_tick),
        .cfg_bag_exp (cfg_bag_exp), .cfg_max_len (cfg_max_len),
        .req_valid (req_valid), .req_link (req_link), .req_len (req_len),
        .req_err (req_err), .grant_valid (grant_valid),
        .grant_link (grant_link), .grant_len (grant_len), .tx_done (tx_done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles expected under 50000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; ms_tick = 1'b0; req_valid = 1'b0;
        req_link = '0; req_len = '0; tx_done = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic send_req(input int l, input int len);
        req_valid = 1'b1; req_link = 2'(l); req_len = LW'(len);
        step();
        req_valid = 1'b0;
    endtask

    task automatic pulse_tick();
        ms_tick = 1'b1; step(); ms_tick = 1'b0;
    endtask

    task automatic pulse_done();
        tx_done = 1'b1; step(); tx_done = 1'b0;
    endtask

    task automatic expect_grant(input string tag, input int l, input int len);
        chk(grant_valid == 1'b1, tag, "grant_valid", int'(grant_valid), 1);
        chk(int'(grant_link) == l, tag, "grant_link", int'(grant_link), l);
        chk(int'(grant_len) == len, tag, "grant_len", int'(grant_len), len);
    endtask

    task automatic wait_grant(input string tag, input int l, input int len);
        for (int k = 0; k < 20 && !grant_valid; k++) step();
        expect_grant(tag, l, len);
    endtask

    // R1, R2: reset state and first-grant latency
    task automatic t_reset();
        apply_reset();
        chk(grant_valid == 1'b0, "R1", "grant_valid after reset", int'(grant_valid), 0);
        chk(req_err == 1'b0, "R1", "req_err after reset", int'(req_err), 0);
        send_req(3, 1500);
        chk(grant_valid == 1'b0, "R2", "grant one edge after request", int'(grant_valid), 0);
        step();
        expect_grant("R1", 3, 1500);
    endtask

    // R3: grant held until done
    task automatic t_hold();
        apply_reset();
        send_req(1, 50);
        step();
        expect_grant("R2", 1, 50);
        repeat (4) step();
        expect_grant("R3", 1, 50);
        pulse_done();
        chk(grant_valid == 1'b0, "R3", "grant_valid after done", int'(grant_valid), 0);
    endtask

    // R5: link 0 exponent 2 -> 4 strobes; strobe on issuing edge ignored
    task automatic t_bag();
        apply_reset();
        send_req(0, 10);
        ms_tick = 1'b1; step(); ms_tick = 1'b0;
        expect_grant("R5", 0, 10);
        pulse_done();
        send_req(0, 11);
        repeat (3) pulse_tick();
        step();
        chk(grant_valid == 1'b0, "R5", "grant after 3 strobes", int'(grant_valid), 0);
        pulse_tick();
        chk(grant_valid == 1'b0, "R5", "grant on edge of 4th strobe", int'(grant_valid), 0);
        step();
        expect_grant("R5", 0, 11);
    endtask

    // R6: length policing on link 3 (cap 1500, exponent 3)
    task automatic t_len();
        apply_reset();
        send_req(3, 1501);
        chk(req_err == 1'b1, "R6", "req_err over cap", int'(req_err), 1);
        step();
        chk(req_err == 1'b0, "R6", "req_err one cycle only", int'(req_err), 0);
        repeat (3) step();
        chk(grant_valid == 1'b0, "R6", "rejected request granted", int'(grant_valid), 0);
        send_req(3, 1500);
        chk(req_err == 1'b0, "R6", "req_err at cap", int'(req_err), 0);
        step();
        expect_grant("R6", 3, 1500);
    endtask

    // R4, R7: one outstanding grant, wrap-around order 2,3,0 after 1
    task automatic t_rr();
        apply_reset();
        send_req(1, 21);
        step();
        expect_grant("R7", 1, 21);
        send_req(0, 20);
        send_req(2, 22);
        send_req(3, 23);
        repeat (2) step();
        expect_grant("R4", 1, 21);
        pulse_done();
        chk(grant_valid == 1'b0, "R4", "gap cycle after release", int'(grant_valid), 0);
        wait_grant("R7", 2, 22);
        pulse_done();
        wait_grant("R7", 3, 23);
        pulse_done();
        wait_grant("R7", 0, 20);
    endtask

    // R8, R9: counter drains during own grant; length replacement
    task automatic t_run_replace();
        apply_reset();
        send_req(2, 30);
        step();
        expect_grant("R8", 2, 30);
        send_req(2, 31);
        send_req(1, 40);
        send_req(1, 41);
        pulse_tick();
        pulse_tick();
        pulse_done();
        wait_grant("R9", 1, 41);
        pulse_done();
        wait_grant("R8", 2, 31);
    endtask

    initial begin
        cfg_bag_exp = {3'd3, 3'd1, 3'd0, 3'd2};
        cfg_max_len = {LW'(1500), LW'(300), LW'(200), LW'(100)};
        t_reset();
        t_hold();
        t_bag();
        t_len();
        t_rr();
        t_run_replace();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule